// File: doc/BRIEF.md
# Transmit/Receive Descriptor Ring Sequencer

This block owns the descriptor table of a network MAC and walks two rings over it: a transmit ring and a receive ring. Both rings share one table. A split register gives the number of leading entries that belong to transmit, and the receive entries start right after them. Firmware reaches the split register and every table word through a 32-bit register port.

Each descriptor holds two words. One is a control/status word that carries the length in its upper half. The other is a buffer address. For each ring, the sequencer waits for the descriptor at its pointer to be handed over to hardware. It then presents the buffer address and length to a MAC core, and takes the completion report from that core. It closes the descriptor with one write, which clears the ownership bit and stores the status flags (plus, for receive, the length). It then pulses a frame or error event if the descriptor asked for an interrupt.

A ring returns to its first entry when the closed descriptor carries a wrap bit, or when the pointer reaches the last entry of its ring. A frame that arrives while the receive descriptor is still owned by software is dropped, and the block reports it.

Top module: `bd_ring_seq`

## Requirements
- R1: The split register sits at byte address 0x000. It resets to NUM_DESC/2. A write stores min(value, NUM_DESC), and a read returns the stored value. Every write to it returns the transmit pointer to index 0 and the receive pointer to the new split index.
- R2: Descriptor i occupies byte addresses 0x400 + 8*i (control/status word) and 0x404 + 8*i (buffer address). Both words read back what firmware last wrote.
- R3: When the transmit descriptor at the pointer has bit 15 (ready) set, tx_req rises. While tx_req is high, tx_buf_addr is the descriptor's address word, tx_len is bits 31:16, tx_pad is bit 12 and tx_crc is bit 11. While bit 15 is clear, tx_req stays low.
- R4: After tx_done, the descriptor's control/status word becomes {bits 31:16 unchanged, bit 15 = 0, bits 14:9 unchanged, bits 8:0 = tx_status}, written in one step.
- R5: On transmit completion of a descriptor with bit 14 set, exactly one one-cycle pulse occurs. It is tx_err_evt if tx_status has any of bits 0, 2, 3 or 8 set, and tx_frame_evt otherwise. With bit 14 clear, neither event pulses.
- R6: After completion, the transmit pointer moves to index+1. It returns to 0 instead when the descriptor's bit 13 (wrap) is set or the index is split-1.
- R7: When rx_start arrives and the receive descriptor at the pointer has bit 15 (empty) set, rx_busy rises on the next cycle. rx_buf_addr then shows that descriptor's address word until the frame ends.
- R8: After rx_done, the receive descriptor's word becomes {rx_len, bit 15 = 0, bits 14:9 unchanged, bits 8:0 = rx_flags}. The length is stored as given, including the 4-byte check sequence.
- R9: On receive completion of a descriptor with bit 14 set, rx_err_evt pulses if any of rx_flags bits 7:0 is set. Otherwise rx_frame_evt pulses, and that includes the case where only bit 8 (control frame) is set. With bit 14 clear, neither event pulses.
- R10: After completion, the receive pointer moves to index+1. It returns to the split index instead when the descriptor's wrap bit is set or the index is NUM_DESC-1.
- R11: An rx_start that meets a descriptor with bit 15 clear, an empty receive ring (split = NUM_DESC) or a frame already in progress pulses rx_drop_evt once. It leaves the descriptor word and the receive pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 11 | Register port byte address |
| reg_wdata | input | 32 | Register port write data |
| reg_rdata | output | 32 | Register port read data (combinational) |
| tx_req | output | 1 | Transmit descriptor handed to MAC core |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit frame length |
| tx_pad | output | 1 | Pad short frame request |
| tx_crc | output | 1 | Append check sequence request |
| tx_done | input | 1 | MAC core finished the transmit frame |
| tx_status | input | 9 | Transmit completion flags |
| rx_start | input | 1 | A frame begins arriving |
| rx_busy | output | 1 | Receive buffer granted, frame in progress |
| rx_buf_addr | output | 32 | Receive buffer address |
| rx_done | input | 1 | MAC core finished the receive frame |
| rx_len | input | 16 | Received length including check sequence |
| rx_flags | input | 9 | Receive completion flags |
| tx_frame_evt | output | 1 | Transmit frame event pulse |
| tx_err_evt | output | 1 | Transmit error event pulse |
| rx_frame_evt | output | 1 | Receive frame event pulse |
| rx_err_evt | output | 1 | Receive error event pulse |
| rx_drop_evt | output | 1 | Arriving frame dropped pulse |

## Verification
The assertions assume that firmware leaves alone any descriptor the sequencer currently owns. They also assume that the split register is not rewritten while a frame is in progress, that tx_done and rx_done arrive only while tx_req or rx_busy is high, and that rx_start is held low during reset. The stimulus keeps to these rules by running one transfer at a time. It re-arms a descriptor only after its completion has been written back, and it changes the split register only between phases. Within those rules, lengths, flags, interrupt and wrap bits, and whether a receive descriptor is armed at all are all chosen at random.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;

  localparam int OWN_BIT  = 15;
  localparam int IRQ_BIT  = 14;
  localparam int WRAP_BIT = 13;
  localparam int PAD_BIT  = 12;
  localparam int CRC_BIT  = 11;

  localparam logic [8:0] TX_ERR_MASK = 9'h10D;
  localparam logic [8:0] RX_ERR_MASK = 9'h0FF;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BUSY, SEQ_WB} seq_state_e;

  // Closed descriptor: new length, ownership released, control kept, flags stored.
  function automatic logic [31:0] close_desc(input logic [31:0] orig,
                                             input logic [15:0] len,
                                             input logic [8:0]  flags);
    return {len, 1'b0, orig[14:9], flags};
  endfunction

  function automatic logic is_error(input logic [8:0] flags, input logic [8:0] mask);
    return |(flags & mask);
  endfunction

  function automatic int unsigned ring_next(input int unsigned idx, input logic wrap,
                                            input int unsigned last, input int unsigned first);
    if (wrap || idx >= last) return first;
    return idx + 1;
  endfunction

  function automatic int unsigned cap_split(input logic [31:0] val, input int unsigned max_n);
    if (val > max_n) return max_n;
    return int'(val);
  endfunction

endpackage

// File: rtl/bd_table.sv
module bd_table #(
  parameter int NUM_DESC = 128,
  parameter int IDX_W    = 7,
  parameter int NRD      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fw_wr,
  input  logic [IDX_W-1:0] fw_idx,
  input  logic             fw_is_addr,
  input  logic [31:0]      fw_data,
  input  logic             wb_wr,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [31:0]      wb_data,
  input  logic [IDX_W-1:0] rd_idx  [NRD],
  output logic [31:0]      rd_stat [NRD],
  output logic [31:0]      rd_addr [NRD]
);

  logic [31:0] stat_mem [NUM_DESC];
  logic [31:0] addr_mem [NUM_DESC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DESC; i++) stat_mem[i] <= '0;
    end else if (fw_wr && !fw_is_addr) begin
      stat_mem[fw_idx] <= fw_data;
    end else if (wb_wr) begin
      stat_mem[wb_idx] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (fw_wr && fw_is_addr) addr_mem[fw_idx] <= fw_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_stat[g] = stat_mem[rd_idx[g]];
    assign rd_addr[g] = addr_mem[rd_idx[g]];
  end

  // R4: the status write-back never collides with a firmware status write
  p_wb_yields_fw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_wr && fw_wr && !fw_is_addr));

endmodule

// File: rtl/bd_tx_seq.sv
module bd_tx_seq
  import bd_ring_pkg::*;
#(
  parameter int NUM_DESC = 128,
  parameter int IDX_W    = 7,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] tx_num,
  input  logic [31:0]      cur_stat,
  input  logic [31:0]      cur_addr,
  output logic [IDX_W-1:0] tx_ptr,
  output logic             tx_req,
  output logic [31:0]      tx_buf_addr,
  output logic [15:0]      tx_len,
  output logic             tx_pad,
  output logic             tx_crc,
  input  logic             tx_done,
  input  logic [8:0]       tx_status,
  output logic             wb_req,
  input  logic             wb_gnt,
  output logic [IDX_W-1:0] wb_idx,
  output logic [31:0]      wb_data,
  output logic             tx_frame_evt,
  output logic             tx_err_evt
);

  seq_state_e       state;
  logic [IDX_W-1:0] ptr;
  logic [31:0]      desc_q;
  logic [31:0]      addr_q;
  logic [8:0]       res_q;

  logic             start_w;
  logic             done_w;
  logic             close_w;
  logic             err_w;
  logic [IDX_W-1:0] ptr_nxt;

  assign start_w = (state == SEQ_IDLE) && (tx_num != '0) && cur_stat[OWN_BIT];
  assign done_w  = (state == SEQ_BUSY) && tx_done;
  assign close_w = (state == SEQ_WB) && wb_gnt;
  assign err_w   = is_error(res_q, TX_ERR_MASK);
  assign ptr_nxt = IDX_W'(ring_next(32'(ptr), desc_q[WRAP_BIT],
                                    32'(tx_num) - 32'd1, 32'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SEQ_IDLE;
      ptr          <= '0;
      desc_q       <= '0;
      addr_q       <= '0;
      res_q        <= '0;
      tx_frame_evt <= 1'b0;
      tx_err_evt   <= 1'b0;
    end else begin
      tx_frame_evt <= 1'b0;
      tx_err_evt   <= 1'b0;
      if (restart) begin
        state <= SEQ_IDLE;
        ptr   <= '0;
      end else begin
        unique case (state)
          SEQ_IDLE: if (start_w) begin
            desc_q <= cur_stat;
            addr_q <= cur_addr;
            state  <= SEQ_BUSY;
          end
          SEQ_BUSY: if (done_w) begin
            res_q <= tx_status;
            state <= SEQ_WB;
          end
          SEQ_WB: if (close_w) begin
            tx_err_evt   <= desc_q[IRQ_BIT] && err_w;
            tx_frame_evt <= desc_q[IRQ_BIT] && !err_w;
            ptr          <= ptr_nxt;
            state        <= SEQ_IDLE;
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign tx_ptr      = ptr;
  assign tx_req      = (state == SEQ_BUSY);
  assign tx_buf_addr = addr_q;
  assign tx_len      = desc_q[31:16];
  assign tx_pad      = desc_q[PAD_BIT];
  assign tx_crc      = desc_q[CRC_BIT];
  assign wb_req      = (state == SEQ_WB);
  assign wb_idx      = ptr;
  assign wb_data     = close_desc(desc_q, desc_q[31:16], res_q);

  // R6: the transmit pointer stays inside the transmit ring
  p_ptr_in_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_num != '0) |-> (32'(ptr) < 32'(tx_num)));

  // R3: a request is held until the MAC core reports completion
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done && !restart) |=> tx_req);

  // R3: a request only starts from a descriptor owned by hardware
  p_req_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> $past(cur_stat[OWN_BIT]));

  // R5: an event follows only a write-back cycle
  p_evt_after_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_frame_evt || tx_err_evt) |-> $past(state == SEQ_WB));

endmodule

// File: rtl/bd_rx_seq.sv
module bd_rx_seq
  import bd_ring_pkg::*;
#(
  parameter int NUM_DESC = 128,
  parameter int IDX_W    = 7,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [IDX_W-1:0] restart_first,
  input  logic [CNT_W-1:0] tx_num,
  input  logic [31:0]      cur_stat,
  input  logic [31:0]      cur_addr,
  output logic [IDX_W-1:0] rx_ptr,
  input  logic             rx_start,
  output logic             rx_busy,
  output logic [31:0]      rx_buf_addr,
  input  logic             rx_done,
  input  logic [15:0]      rx_len,
  input  logic [8:0]       rx_flags,
  output logic             wb_req,
  input  logic             wb_gnt,
  output logic [IDX_W-1:0] wb_idx,
  output logic [31:0]      wb_data,
  output logic             rx_frame_evt,
  output logic             rx_err_evt,
  output logic             rx_drop_evt
);

  seq_state_e       state;
  logic [IDX_W-1:0] ptr;
  logic [31:0]      desc_q;
  logic [31:0]      addr_q;
  logic [15:0]      len_q;
  logic [8:0]       flg_q;

  logic             ring_ok;
  logic             accept_w;
  logic             close_w;
  logic             err_w;
  logic [IDX_W-1:0] ptr_nxt;

  assign ring_ok  = 32'(tx_num) < NUM_DESC;
  assign accept_w = (state == SEQ_IDLE) && rx_start && ring_ok && cur_stat[OWN_BIT];
  assign close_w  = (state == SEQ_WB) && wb_gnt;
  assign err_w    = is_error(flg_q, RX_ERR_MASK);
  assign ptr_nxt  = IDX_W'(ring_next(32'(ptr), desc_q[WRAP_BIT],
                                     NUM_DESC - 1, 32'(tx_num)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SEQ_IDLE;
      ptr          <= IDX_W'(32'(tx_num));
      desc_q       <= '0;
      addr_q       <= '0;
      len_q        <= '0;
      flg_q        <= '0;
      rx_frame_evt <= 1'b0;
      rx_err_evt   <= 1'b0;
      rx_drop_evt  <= 1'b0;
    end else begin
      rx_frame_evt <= 1'b0;
      rx_err_evt   <= 1'b0;
      rx_drop_evt  <= rx_start && !accept_w;
      if (restart) begin
        state <= SEQ_IDLE;
        ptr   <= restart_first;
      end else begin
        unique case (state)
          SEQ_IDLE: if (accept_w) begin
            desc_q <= cur_stat;
            addr_q <= cur_addr;
            state  <= SEQ_BUSY;
          end
          SEQ_BUSY: if (rx_done) begin
            len_q <= rx_len;
            flg_q <= rx_flags;
            state <= SEQ_WB;
          end
          SEQ_WB: if (close_w) begin
            rx_err_evt   <= desc_q[IRQ_BIT] && err_w;
            rx_frame_evt <= desc_q[IRQ_BIT] && !err_w;
            ptr          <= ptr_nxt;
            state        <= SEQ_IDLE;
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign rx_ptr      = ptr;
  assign rx_busy     = (state == SEQ_BUSY);
  assign rx_buf_addr = addr_q;
  assign wb_req      = (state == SEQ_WB);
  assign wb_idx      = ptr;
  assign wb_data     = close_desc(desc_q, len_q, flg_q);

  // R10: the receive pointer never falls below the split index
  p_ptr_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_num) < NUM_DESC) |-> (32'(ptr) >= 32'(tx_num)));

  // R11: a drop is reported only for an arriving frame
  p_drop_needs_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop_evt |-> $past(rx_start));

  // R7: a granted buffer is held until the frame ends
  p_busy_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && !rx_done && !restart) |=> rx_busy);

  // R9: an event follows only a write-back cycle
  p_evt_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_evt || rx_err_evt) |-> $past(state == SEQ_WB));

endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq
  import bd_ring_pkg::*;
#(
  parameter int NUM_DESC  = 128,
  parameter int RST_SPLIT = NUM_DESC / 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [10:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_req,
  output logic [31:0] tx_buf_addr,
  output logic [15:0] tx_len,
  output logic        tx_pad,
  output logic        tx_crc,
  input  logic        tx_done,
  input  logic [8:0]  tx_status,
  input  logic        rx_start,
  output logic        rx_busy,
  output logic [31:0] rx_buf_addr,
  input  logic        rx_done,
  input  logic [15:0] rx_len,
  input  logic [8:0]  rx_flags,
  output logic        tx_frame_evt,
  output logic        tx_err_evt,
  output logic        rx_frame_evt,
  output logic        rx_err_evt,
  output logic        rx_drop_evt
);

  localparam int IDX_W = $clog2(NUM_DESC);
  localparam int CNT_W = IDX_W + 1;
  localparam int NRD   = 3;

  logic [CNT_W-1:0] split_q;
  logic [CNT_W-1:0] split_wval;
  logic             split_sel;
  logic             split_wr;
  logic             tbl_sel;
  logic [IDX_W-1:0] fw_idx;
  logic             fw_is_addr;
  logic             fw_wr;
  logic             fw_stat_wr;

  logic [IDX_W-1:0] tx_ptr, rx_ptr;
  logic             tx_wb_req, rx_wb_req, tx_wb_gnt, rx_wb_gnt;
  logic [IDX_W-1:0] tx_wb_idx, rx_wb_idx, wb_idx;
  logic [31:0]      tx_wb_data, rx_wb_data, wb_data;

  logic [IDX_W-1:0] rd_idx  [NRD];
  logic [31:0]      rd_stat [NRD];
  logic [31:0]      rd_addr [NRD];

  // Register decode
  assign split_sel  = (reg_addr == '0);
  assign tbl_sel    = reg_addr[10] && (32'(reg_addr[9:3]) < NUM_DESC);
  assign fw_idx     = reg_addr[IDX_W+2:3];
  assign fw_is_addr = reg_addr[2];
  assign fw_wr      = reg_wr && tbl_sel;
  assign fw_stat_wr = fw_wr && !fw_is_addr;
  assign split_wr   = reg_wr && split_sel;
  assign split_wval = CNT_W'(cap_split(reg_wdata, NUM_DESC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        split_q <= CNT_W'(RST_SPLIT);
    else if (split_wr) split_q <= split_wval;
  end

  always_comb begin
    reg_rdata = '0;
    if (split_sel)    reg_rdata = 32'(split_q);
    else if (tbl_sel) reg_rdata = fw_is_addr ? rd_addr[2] : rd_stat[2];
  end

  // Status write-back arbitration: firmware, then transmit, then receive
  assign tx_wb_gnt = tx_wb_req && !fw_stat_wr;
  assign rx_wb_gnt = rx_wb_req && !fw_stat_wr && !tx_wb_req;
  assign wb_idx    = tx_wb_gnt ? tx_wb_idx  : rx_wb_idx;
  assign wb_data   = tx_wb_gnt ? tx_wb_data : rx_wb_data;

  assign rd_idx[0] = tx_ptr;
  assign rd_idx[1] = rx_ptr;
  assign rd_idx[2] = fw_idx;

  bd_table #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .NRD(NRD)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .fw_wr     (fw_wr),
    .fw_idx    (fw_idx),
    .fw_is_addr(fw_is_addr),
    .fw_data   (reg_wdata),
    .wb_wr     (tx_wb_gnt || rx_wb_gnt),
    .wb_idx    (wb_idx),
    .wb_data   (wb_data),
    .rd_idx    (rd_idx),
    .rd_stat   (rd_stat),
    .rd_addr   (rd_addr)
  );

  bd_tx_seq #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (split_wr),
    .tx_num      (split_q),
    .cur_stat    (rd_stat[0]),
    .cur_addr    (rd_addr[0]),
    .tx_ptr      (tx_ptr),
    .tx_req      (tx_req),
    .tx_buf_addr (tx_buf_addr),
    .tx_len      (tx_len),
    .tx_pad      (tx_pad),
    .tx_crc      (tx_crc),
    .tx_done     (tx_done),
    .tx_status   (tx_status),
    .wb_req      (tx_wb_req),
    .wb_gnt      (tx_wb_gnt),
    .wb_idx      (tx_wb_idx),
    .wb_data     (tx_wb_data),
    .tx_frame_evt(tx_frame_evt),
    .tx_err_evt  (tx_err_evt)
  );

  bd_rx_seq #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (split_wr),
    .restart_first(IDX_W'(split_wval)),
    .tx_num       (split_q),
    .cur_stat     (rd_stat[1]),
    .cur_addr     (rd_addr[1]),
    .rx_ptr       (rx_ptr),
    .rx_start     (rx_start),
    .rx_busy      (rx_busy),
    .rx_buf_addr  (rx_buf_addr),
    .rx_done      (rx_done),
    .rx_len       (rx_len),
    .rx_flags     (rx_flags),
    .wb_req       (rx_wb_req),
    .wb_gnt       (rx_wb_gnt),
    .wb_idx       (rx_wb_idx),
    .wb_data      (rx_wb_data),
    .rx_frame_evt (rx_frame_evt),
    .rx_err_evt   (rx_err_evt),
    .rx_drop_evt  (rx_drop_evt)
  );

  // R1: the stored split never exceeds the table size
  p_split_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(split_q) <= NUM_DESC);

  // R1: a split write lands the capped value on the next cycle
  p_split_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    split_wr |=> (split_q == $past(split_wval)));

endmodule

// File: tb/bd_ring_seq_tb.sv
module bd_ring_seq_tb;

  localparam int NUM = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [10:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_req, tx_pad, tx_crc;
  logic [31:0] tx_buf_addr;
  logic [15:0] tx_len;
  logic        tx_done = 1'b0;
  logic [8:0]  tx_status = '0;
  logic        rx_start = 1'b0;
  logic        rx_busy;
  logic [31:0] rx_buf_addr;
  logic        rx_done = 1'b0;
  logic [15:0] rx_len = '0;
  logic [8:0]  rx_flags = '0;
  logic        tx_frame_evt, tx_err_evt, rx_frame_evt, rx_err_evt, rx_drop_evt;

  always #2.5 clk = ~clk;

  bd_ring_seq #(.NUM_DESC(NUM)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req),
    .tx_buf_addr(tx_buf_addr), .tx_len(tx_len), .tx_pad(tx_pad), .tx_crc(tx_crc),
    .tx_done(tx_done), .tx_status(tx_status), .rx_start(rx_start), .rx_busy(rx_busy),
    .rx_buf_addr(rx_buf_addr), .rx_done(rx_done), .rx_len(rx_len), .rx_flags(rx_flags),
    .tx_frame_evt(tx_frame_evt), .tx_err_evt(tx_err_evt), .rx_frame_evt(rx_frame_evt),
    .rx_err_evt(rx_err_evt), .rx_drop_evt(rx_drop_evt)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int c_txf = 0, c_txe = 0, c_rxf = 0, c_rxe = 0, c_drop = 0;
  logic [31:0] mstat [NUM];
  int split = 64;
  int tptr = 0;
  int rptr = 64;

  always @(negedge clk) if (rst_n) begin
    c_txf  += int'(tx_frame_evt);
    c_txe  += int'(tx_err_evt);
    c_rxf  += int'(rx_frame_evt);
    c_rxe  += int'(rx_err_evt);
    c_drop += int'(rx_drop_evt);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_close(input logic [31:0] o, input logic [15:0] l,
                                            input logic [8:0] f);
    logic [31:0] w;
    w = o;
    w[31:16] = l;
    w[15] = 1'b0;
    w[8:0] = f;
    return w;
  endfunction

  function automatic int exp_next(input int idx, input bit wrap, input int last, input int first);
    return (wrap || idx == last) ? first : idx + 1;
  endfunction

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 11'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    reg_addr = 11'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_split(input int v);
    reg_write(0, 32'(v));
    split = (v > NUM) ? NUM : v;
    tptr  = 0;
    rptr  = split;
  endtask

  task automatic run_tx;
    logic [31:0] a, st, rd;
    logic [15:0] len;
    logic [8:0]  res;
    bit irq, wrap, err;
    int f0, e0, idx;
    idx  = tptr;
    len  = 16'($urandom_range(60, 1518));
    irq  = ($urandom % 4) != 0;
    wrap = ($urandom % 4) == 0;
    a    = $urandom;
    st   = {len, 1'b1, irq, wrap, 1'($urandom), 1'($urandom), 2'($urandom), 9'h0};
    reg_write(32'h404 + idx * 8, a);
    reg_write(32'h400 + idx * 8, st);
    for (int k = 0; k < 10 && !tx_req; k++) @(negedge clk);
    chk("R6 tx ring position reached", 32'(tx_req), 32'd1);
    chk("R3 tx_buf_addr", tx_buf_addr, a);
    chk("R3 tx_len", 32'(tx_len), 32'(len));
    chk("R3 tx_pad/tx_crc", {30'd0, tx_pad, tx_crc}, {30'd0, st[12], st[11]});
    res = ($urandom % 2) ? 9'h0 : 9'($urandom);
    f0 = c_txf; e0 = c_txe;
    tx_done = 1'b1; tx_status = res;
    @(negedge clk);
    tx_done = 1'b0; tx_status = '0;
    repeat (3) @(negedge clk);
    reg_read(32'h400 + idx * 8, rd);
    chk("R4 tx status write-back", rd, exp_close(st, len, res));
    chk("R3 tx stalls on unready descriptor", 32'(tx_req), 32'd0);
    err = |(res & 9'h10D);
    chk("R5 tx error events", 32'(c_txe - e0), 32'(irq && err));
    chk("R5 tx frame events", 32'(c_txf - f0), 32'(irq && !err));
    mstat[idx] = exp_close(st, len, res);
    tptr = exp_next(idx, wrap, split - 1, 0);
  endtask

  task automatic run_rx(input bit allow_wrap);
    logic [31:0] a, st, rd;
    logic [15:0] len;
    logic [8:0]  fl;
    bit arm, irq, wrap, err;
    int f0, e0, d0, idx;
    idx  = rptr;
    arm  = ($urandom % 4) != 0;
    irq  = ($urandom % 4) != 0;
    wrap = allow_wrap && (($urandom % 5) == 0);
    a    = $urandom;
    st   = {16'h0, 1'b1, irq, wrap, 4'($urandom), 9'h0};
    if (arm) begin
      reg_write(32'h404 + idx * 8, a);
      reg_write(32'h400 + idx * 8, st);
    end
    d0 = c_drop; f0 = c_rxf; e0 = c_rxe;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    if (arm) begin
      chk("R7 rx_busy after start", 32'(rx_busy), 32'd1);
      chk("R7 rx_buf_addr", rx_buf_addr, a);
      len = 16'($urandom_range(64, 1522));
      case ($urandom % 4)
        0: fl = 9'h100;
        1: fl = 9'($urandom);
        default: fl = 9'h0;
      endcase
      rx_done = 1'b1; rx_len = len; rx_flags = fl;
      @(negedge clk);
      rx_done = 1'b0; rx_len = '0; rx_flags = '0;
      repeat (3) @(negedge clk);
      reg_read(32'h400 + idx * 8, rd);
      chk("R8 rx status write-back", rd, exp_close(st, len, fl));
      err = |(fl & 9'h0FF);
      chk("R9 rx error events", 32'(c_rxe - e0), 32'(irq && err));
      chk("R9 rx frame events", 32'(c_rxf - f0), 32'(irq && !err));
      chk("R7 rx_busy released", 32'(rx_busy), 32'd0);
      mstat[idx] = exp_close(st, len, fl);
      rptr = exp_next(idx, wrap, NUM - 1, split);
    end else begin
      repeat (2) @(negedge clk);
      chk("R11 drop on software-owned descriptor", 32'(c_drop - d0), 32'd1);
      chk("R11 no grant on drop", 32'(rx_busy), 32'd0);
      reg_read(32'h400 + idx * 8, rd);
      chk("R11 descriptor untouched", rd, mstat[idx]);
    end
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int d0;
    void'($urandom(32'd1234));
    for (int i = 0; i < NUM; i++) mstat[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R3 tx_req idle after reset", 32'(tx_req), 32'd0);
    chk("R7 rx_busy idle after reset", 32'(rx_busy), 32'd0);
    reg_read(0, rd);
    chk("R1 split reset value", rd, 32'd64);

    // R1: cap at table size, then empty receive ring drops frames (R11)
    set_split(200);
    reg_read(0, rd);
    chk("R1 split capped", rd, 32'd128);
    d0 = c_drop;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 drop with no receive ring", 32'(c_drop - d0), 32'd1);

    set_split(4);
    reg_read(0, rd);
    chk("R1 split write", rd, 32'd4);

    // R2: table layout and readback
    begin
      logic [31:0] v;
      v = $urandom;
      reg_write(32'h404 + 70 * 8, v);
      reg_read(32'h404 + 70 * 8, rd);
      chk("R2 address word readback", rd, v);
      v = $urandom & 32'hFFFF7FFF;
      reg_write(32'h400 + 100 * 8, v);
      mstat[100] = v;
      reg_read(32'h400 + 100 * 8, rd);
      chk("R2 status word readback", rd, v);
    end

    // R3: no transmit while nothing is ready
    repeat (5) @(negedge clk);
    chk("R3 stall with no ready descriptor", 32'(tx_req), 32'd0);

    for (int i = 0; i < 16; i++) run_tx();
    for (int i = 0; i < 24; i++) run_rx(1'b1);

    // R10: wrap at the last table entry
    set_split(124);
    for (int i = 0; i < 12; i++) run_rx(1'b0);

    // R1: split write returns pointers to their ring starts
    set_split(4);
    run_tx();
    run_rx(1'b0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

endmodule